// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal by counting its rising edges during a gate window. The window is timed from the crystal reference clock. A prescaler turns the reference into a millisecond tick, and a tick counter sets how long the window stays open. One input tells the prescaler which of two crystal frequencies is fitted, so the window lasts the same time with either crystal. A 2-bit code picks one of four window lengths.

A start pulse clears the counter, captures the crystal and window settings, and opens the window. The IF input is brought into the reference domain through two flops. Each rising edge seen while the window is open adds one to a counter, and the counter saturates at full scale. When the window closes, the final count is copied into a result register and a done flag is raised.

The serial read path takes the result in parallel into a shift register. The bits then leave through one serial pin, most significant bit first. They appear there only while the 3-bit output-select code chooses the counter.

Top module: `ifc_counter`

## Requirements
- R1: After reset, busy, done, result and serOut are all 0.
- R2: The window lasts exactly ticks × cycles-per-tick reference cycles, and busy is high for all of them. The gateSel code sets the tick count: 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 32 and 2'b11 gives 64.
- R3: xtalSel=0 sets cycles-per-tick to DIV_A and xtalSel=1 sets it to DIV_B.
- R4: Rising edges on ifIn that fall inside the window are counted exactly. This holds when every high phase and every low phase of ifIn lasts at least one reference cycle.
- R5: The count stops at 2^CNT_W−1 and does not wrap.
- R6: done goes to 1 in the same cycle that busy falls at the end of a window. A start clears done. busy and done are never high together.
- R7: result changes only when a window closes. Edges on ifIn outside a window leave result unchanged.
- R8: A start during an open window restarts it with a full new window. Changes to gateSel or xtalSel while a window is open have no effect on that window.
- R9: rdLoad copies result into the shift register, and each rdShift moves it one bit toward the MSB, filling with 0. While outSel equals 3'b010, serOut carries the shift register's MSB. For any other outSel value, serOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| xtalSel | input | 1 | Crystal choice: 0 uses DIV_A, 1 uses DIV_B |
| gateSel | input | 2 | Window length code |
| start | input | 1 | Starts or restarts a measurement |
| ifIn | input | 1 | Asynchronous IF signal |
| outSel | input | 3 | Serial output content select |
| rdLoad | input | 1 | Copies the result into the shift register |
| rdShift | input | 1 | Shifts the register one bit toward the MSB |
| busy | output | 1 | Window open |
| done | output | 1 | Measurement complete |
| result | output | CNT_W | Latched count, parallel |
| serOut | output | 1 | Serial data, MSB first |

## Verification
The bench runs all eight combinations of crystal and window code with small prescaler divisors. In each run it measures how long busy stays high and counts a known burst of pulses. A wrong tick count, a wrong divisor or an off-by-one in the close logic each show up as a different busy length. A dense toggle across the longest window drives the count into saturation, which separates a counter that clamps from one that wraps. Pulses sent after done, a change of settings during an open window and a second start during a window check that the latched values hold and that a restart opens a full window. Reading the result out serially under both the selecting code and a non-selecting code checks the bit order and the output gating.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  // Strobes from the gate control to the datapath
  typedef struct packed {
    logic clear;   // zero the edge counter (start)
    logic enable;  // window open, count edges
    logic close;   // last cycle of the window, latch result
  } ifcStrobe_t;

  localparam logic [2:0] SEL_COUNT = 3'b010;

  function automatic int unsigned gateTicks(input logic [1:0] code);
    case (code)
      2'b00:   return 4;
      2'b01:   return 8;
      2'b10:   return 32;
      default: return 64;
    endcase
  endfunction
endpackage

// File: rtl/ifc_gate_ctrl.sv
module ifc_gate_ctrl
  import ifc_pkg::*;
#(
  parameter int unsigned DIV_A = 4500,
  parameter int unsigned DIV_B = 7200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       xtalSel,
  input  logic [1:0] gateSel,
  input  logic       start,
  output ifcStrobe_t strb,
  output logic       busy,
  output logic       done
);
  localparam int unsigned MAX_DIV = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int unsigned PRE_W   = $clog2(MAX_DIV + 1);
  localparam int unsigned TICK_W  = 7;

  logic [PRE_W-1:0]  preCnt, divLast;
  logic [TICK_W-1:0] tickCnt, tickLast;
  logic              gateOpen, doneQ;
  logic              tickEnd, lastCycle;

  assign tickEnd   = (preCnt == divLast);
  assign lastCycle = tickEnd && (tickCnt == tickLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt   <= '0;
      tickCnt  <= '0;
      divLast  <= '0;
      tickLast <= '0;
      gateOpen <= 1'b0;
      doneQ    <= 1'b0;
    end else if (start) begin
      preCnt   <= '0;
      tickCnt  <= '0;
      divLast  <= PRE_W'((xtalSel ? DIV_B : DIV_A) - 1);
      tickLast <= TICK_W'(gateTicks(gateSel) - 1);
      gateOpen <= 1'b1;
      doneQ    <= 1'b0;
    end else if (gateOpen) begin
      if (tickEnd) begin
        preCnt  <= '0;
        tickCnt <= tickCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
      if (lastCycle) begin
        gateOpen <= 1'b0;
        doneQ    <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.clear  = start;
    strb.enable = gateOpen && !start;
    strb.close  = gateOpen && !start && lastCycle;
  end

  assign busy = gateOpen;
  assign done = doneQ;

  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));
  // R6
  done_at_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $fell(busy));
  // R3
  prescaler_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (preCnt <= PRE_W'(MAX_DIV - 1)));
endmodule

// File: rtl/ifc_datapath.sv
module ifc_datapath
  import ifc_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  ifcStrobe_t       strb,
  input  logic             ifIn,
  input  logic [2:0]       outSel,
  input  logic             rdLoad,
  input  logic             rdShift,
  output logic [CNT_W-1:0] result,
  output logic             serOut
);
  logic             sync1, sync2, syncPrev, riseEdge;
  logic [CNT_W-1:0] count, nextCount, shiftReg;
  logic             full;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1    <= 1'b0;
      sync2    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      sync1    <= ifIn;
      sync2    <= sync1;
      syncPrev <= sync2;
    end
  end

  assign riseEdge = sync2 && !syncPrev;
  assign full     = &count;

  always_comb begin
    nextCount = count;
    if (strb.enable && riseEdge && !full) nextCount = count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      result <= '0;
    end else begin
      count <= strb.clear ? '0 : nextCount;
      if (strb.close) result <= nextCount;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        shiftReg <= '0;
    else if (rdLoad)  shiftReg <= result;
    else if (rdShift) shiftReg <= {shiftReg[CNT_W-2:0], 1'b0};
  end

  assign serOut = (outSel == SEL_COUNT) && shiftReg[CNT_W-1];

  // R4
  count_monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clear |=> (count >= $past(count)));
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && !strb.clear) |=> (&count));
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.close |=> $stable(result));
endmodule

// File: rtl/ifc_counter.sv
module ifc_counter
  import ifc_pkg::*;
#(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned DIV_A = 4500,
  parameter int unsigned DIV_B = 7200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xtalSel,
  input  logic [1:0]       gateSel,
  input  logic             start,
  input  logic             ifIn,
  input  logic [2:0]       outSel,
  input  logic             rdLoad,
  input  logic             rdShift,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] result,
  output logic             serOut
);
  ifcStrobe_t strb;

  ifc_gate_ctrl #(.DIV_A(DIV_A), .DIV_B(DIV_B)) ctrl (
    .clk(clk), .rstN(rstN), .xtalSel(xtalSel), .gateSel(gateSel),
    .start(start), .strb(strb), .busy(busy), .done(done)
  );

  ifc_datapath #(.CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ifIn(ifIn), .outSel(outSel),
    .rdLoad(rdLoad), .rdShift(rdShift), .result(result), .serOut(serOut)
  );
endmodule

// File: tb/ifc_counter_test.sv
module ifc_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 7;
  localparam int DA = 3;
  localparam int DB = 5;

  logic clk = 1'b0, rstN = 1'b0, xtalSel = 1'b0, start = 1'b0, ifIn = 1'b0;
  logic rdLoad = 1'b0, rdShift = 1'b0;
  logic [1:0] gateSel = 2'b00;
  logic [2:0] outSel = 3'b010;
  logic busy, done, serOut;
  logic [W-1:0] result;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifc_counter #(.CNT_W(W), .DIV_A(DA), .DIV_B(DB)) uut (
    .clk(clk), .rstN(rstN), .xtalSel(xtalSel), .gateSel(gateSel),
    .start(start), .ifIn(ifIn), .outSel(outSel), .rdLoad(rdLoad),
    .rdShift(rdShift), .busy(busy), .done(done), .result(result),
    .serOut(serOut)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ticksOf(input int g);
    return (g == 0) ? 4 : (g == 1) ? 8 : (g == 2) ? 32 : 64;
  endfunction

  task automatic pulseStart();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  // counts negedges with busy high; optional restart and config change
  task automatic runWindow(input int nPulse, input int toggleAll,
                           input int restartAt, input int changeAt,
                           output int busyLen, output int doneDuring);
    busyLen = 0; doneDuring = 0;
    fork
      begin
        repeat (2) @(negedge clk);
        if (toggleAll != 0) begin
          while (busy) begin ifIn = 1'b1; @(negedge clk); ifIn = 1'b0; @(negedge clk); end
        end else begin
          for (int p = 0; p < nPulse; p++) begin
            ifIn = 1'b1; @(negedge clk); ifIn = 1'b0; @(negedge clk);
          end
        end
      end
      begin
        while (busy && busyLen < 5000) begin
          busyLen++;
          if (done) doneDuring++;
          if (busyLen == restartAt) start = 1'b1;
          if (busyLen == changeAt) begin gateSel = ~gateSel; xtalSel = ~xtalSel; end
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
  endtask

  task automatic readOut(input int exp, input string req);
    rdLoad = 1'b1; @(negedge clk); rdLoad = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      check(req, int'(serOut), (outSel == 3'b010) ? ((exp >> i) & 1) : 0);
      rdShift = 1'b1; @(negedge clk);
    end
    rdShift = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int len, dd, g, k;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 result", int'(result), 0);
    check("R1 serOut", int'(serOut), 0);
    rstN = 1'b1; @(negedge clk);

    // R2 R3 R4 R6: sweep crystal and window codes
    for (int xs = 0; xs < 2; xs++) begin
      for (int gs = 0; gs < 4; gs++) begin
        xtalSel = xs[0]; gateSel = gs[1:0];
        g = ticksOf(gs) * (xs ? DB : DA);
        k = g / 4 - 2;
        pulseStart();
        check("R6 busy after start", int'(busy), 1);
        runWindow(k, 0, -1, -1, len, dd);
        check("R2 R3 window length", len, g);
        check("R6 done cleared while busy", dd, 0);
        check("R6 done at end", int'(done), 1);
        check("R4 edge count", int'(result), k);
      end
    end

    // R7: edges after the window do not alter result
    k = int'(result);
    repeat (5) begin ifIn = 1'b1; @(negedge clk); ifIn = 1'b0; @(negedge clk); end
    check("R7 result held", int'(result), k);

    // R9 serial readout, selecting and non-selecting code
    outSel = 3'b010; readOut(k, "R9 serial bit");
    outSel = 3'b101; readOut(k, "R9 deselected bit");
    outSel = 3'b010;

    // R5 saturation: dense toggle across longest window
    xtalSel = 1'b1; gateSel = 2'b11;
    pulseStart();
    runWindow(0, 1, -1, -1, len, dd);
    ifIn = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 saturated", int'(result), (1 << W) - 1);

    // R8 config change during a window is ignored
    xtalSel = 1'b0; gateSel = 2'b00;
    pulseStart();
    runWindow(1, 0, -1, 3, len, dd);
    check("R8 config ignored", len, 4 * DA);
    check("R8 count", int'(result), 1);

    // R8 restart during a window
    xtalSel = 1'b0; gateSel = 2'b01;
    pulseStart();
    runWindow(0, 0, 10, -1, len, dd);
    check("R8 restart length", len, 10 + 8 * DA);
    check("R8 no done during restart", dd, 0);
    check("R6 done after restart", int'(done), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule